// File: doc/BRIEF.md
# Dual-Cycle-Deselect Burst SRAM Controller

This block sits in front of a small synchronous storage array and interprets the per-cycle control pins of a burst SRAM. On each rising clock edge it samples three chip enables, two burst-start strobes (a processor-side one and a controller-side one), a burst-advance pin and the write strobes. From these it picks one operation: start a read or write at the external address, continue the burst at the next address, hold the burst at the current address, deselect, or stay idle when no burst is open.

Read data leaves through one of two paths chosen by a static mode pin. In flow-through mode the word registered at the read edge goes straight to the outputs. In pipeline mode a second register stage adds a cycle of latency. A valid bit travels with the data through the same stages, so a deselect takes as long to reach the outputs as a read does. The bus drive enable is that valid bit gated by an asynchronous output enable.

Top module: `dcd_sram_ctl`

## Requirements
- R1: After synchronous reset, `rdata_drive` is 0 and `rdata` is 0.
- R2: The chip counts as selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. If a start strobe is taken while the chip is not selected, the cycle is a deselect: nothing is read or written.
- R3: With the chip selected and `proc_start_n`=0, the cycle is a read at `addr`, whatever the write strobes say. The array is left unchanged.
- R4: `proc_start_n` has no effect while `sel_a_n`=1. With `ctl_start_n`=1 and a burst open, the cycle follows the advance pin at the burst's own address and ignores `addr`.
- R5: With the chip selected, `proc_start_n`=1 and `ctl_start_n`=0, a burst starts at `addr`. It is a write if the decoded write is active and a read otherwise.
- R6: With both start strobes high and a burst open, `burst_adv_n`=0 moves to the next address and `burst_adv_n`=1 repeats the current one. The low BURST_W address bits count upward and wrap, and the upper bits stay fixed.
- R7: Write decode. `wr_all_n`=0 writes every byte. With `wr_all_n`=1 and `wr_bytes_n`=0, each `lane_wr_n` bit that is 0 writes its byte: bit 0 covers `wdata[7:0]` and bit 1 covers `wdata[15:8]`. Any other combination is a read.
- R8: Read latency. In flow-through mode (`pipe_mode`=0), a read sampled at edge k drives its data right after edge k. In pipeline mode (`pipe_mode`=1), it does so right after edge k+1.
- R9: A deselect sampled at edge k releases the bus after edge k in flow-through mode and after edge k+1 in pipeline mode. A read issued just before the deselect still drives for its full cycle.
- R10: `out_en_n`=1 forces `rdata_drive` to 0 and `rdata` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the drive at once.
- R11: Write cycles never set the output valid bit.
- R12: With both start strobes high and no burst open (after reset or a deselect), the cycle is idle. Nothing is written and nothing is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Active-low enable; also gates the processor strobe |
| sel_b | input | 1 | Active-high enable |
| sel_c_n | input | 1 | Active-low enable |
| proc_start_n | input | 1 | Processor burst-start strobe, always a read |
| ctl_start_n | input | 1 | Controller burst-start strobe, read or write |
| burst_adv_n | input | 1 | Low advances an open burst, high holds it |
| wr_all_n | input | 1 | Global write, all bytes |
| wr_bytes_n | input | 1 | Enables the per-byte write strobes |
| lane_wr_n | input | LANES | Per-byte write strobes, bit i for byte i |
| addr | input | ADDR_W | External word address |
| wdata | input | DATA_W | Write data |
| pipe_mode | input | 1 | 1 = pipeline output, 0 = flow-through |
| out_en_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | DATA_W | Read data, 0 when not driven |
| rdata_drive | output | 1 | Bus drive enable (tri-state control) |

## Verification
If the burst address register goes wrong, the next continue or hold read returns the wrong word, one cycle after that edge in flow-through mode and two in pipeline mode. If the op decode goes wrong, the array is either left unchanged or written when it should not be. That shows up at the next read-back of the address, or as `rdata_drive` rising on a write or deselect cycle. If the valid bit stops shifting correctly, the drive enable rises or falls one cycle off from the read-latency and deselect timing. The bench probes each of these edges one cycle at a time.

// File: rtl/dcd_sram_pkg.sv
`timescale 1ns/1ps
package dcd_sram_pkg;

    localparam int LANE_BITS = 8;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_DESEL,
        OP_RD_EXT,
        OP_WR_EXT,
        OP_RD_NEXT,
        OP_WR_NEXT,
        OP_RD_HOLD,
        OP_WR_HOLD
    } sram_op_e;

    function automatic logic op_is_read(sram_op_e op);
        return (op == OP_RD_EXT) || (op == OP_RD_NEXT) || (op == OP_RD_HOLD);
    endfunction

    function automatic logic op_is_write(sram_op_e op);
        return (op == OP_WR_EXT) || (op == OP_WR_NEXT) || (op == OP_WR_HOLD);
    endfunction

    function automatic logic op_is_access(sram_op_e op);
        return op_is_read(op) || op_is_write(op);
    endfunction

endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/1ps
module sram_cmd_decode
    import dcd_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             proc_start_n,
    input  logic             ctl_start_n,
    input  logic             burst_adv_n,
    input  logic             wr_all_n,
    input  logic             wr_bytes_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             burst_live,
    output sram_op_e         op,
    output logic [LANES-1:0] lane_mask
);
    logic chosen;
    logic wr_any;

    always_comb begin
        if (!wr_all_n)        lane_mask = '1;
        else if (!wr_bytes_n) lane_mask = ~lane_wr_n;
        else                  lane_mask = '0;
    end

    assign wr_any = |lane_mask;
    assign chosen = !sel_a_n && sel_b && !sel_c_n;

    always_comb begin
        if (!sel_a_n && !proc_start_n)
            op = chosen ? OP_RD_EXT : OP_DESEL;
        else if (!ctl_start_n)
            op = chosen ? (wr_any ? OP_WR_EXT : OP_RD_EXT) : OP_DESEL;
        else if (!burst_live)
            op = OP_IDLE;
        else if (!burst_adv_n)
            op = wr_any ? OP_WR_NEXT : OP_RD_NEXT;
        else
            op = wr_any ? OP_WR_HOLD : OP_RD_HOLD;
    end
endmodule

// File: rtl/sram_burst_addr.sv
`timescale 1ns/1ps
module sram_burst_addr
    import dcd_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  sram_op_e          op,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              live
);
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] nxt;

    assign nxt = {cur_q[ADDR_W-1:BURST_W], cur_q[BURST_W-1:0] + 1'b1};

    always_comb begin
        unique case (op)
            OP_RD_EXT, OP_WR_EXT:   eff_addr = addr_in;
            OP_RD_NEXT, OP_WR_NEXT: eff_addr = nxt;
            default:                eff_addr = cur_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            live  <= 1'b0;
        end else if (op == OP_DESEL) begin
            live <= 1'b0;
        end else if (op_is_access(op)) begin
            cur_q <= eff_addr;
            live  <= 1'b1;
        end
    end
endmodule

// File: rtl/sram_store.sv
`timescale 1ns/1ps
module sram_store
    import dcd_sram_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_BITS,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word
);
    logic [DATA_W-1:0] mem [DEPTH];

    assign rd_word = mem[addr];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wr_mask[i])
                mem[addr][i*LANE_BITS +: LANE_BITS] <= wdata[i*LANE_BITS +: LANE_BITS];
        end
    end
endmodule

// File: rtl/sram_out_stage.sv
`timescale 1ns/1ps
module sram_out_stage #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_fire,
    input  logic [DATA_W-1:0] rd_word,
    input  logic              pipe_mode,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] q,
    output logic              drive,
    output logic              a_valid,
    output logic              b_valid
);
    logic [DATA_W-1:0] a_data, b_data;
    logic              sel_valid;
    logic [DATA_W-1:0] sel_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_valid <= 1'b0;
            b_valid <= 1'b0;
            a_data  <= '0;
            b_data  <= '0;
        end else begin
            a_valid <= rd_fire;
            if (rd_fire) a_data <= rd_word;
            b_valid <= a_valid;
            b_data  <= a_data;
        end
    end

    assign sel_valid = pipe_mode ? b_valid : a_valid;
    assign sel_data  = pipe_mode ? b_data  : a_data;
    assign drive     = sel_valid && !out_en_n;
    assign q         = drive ? sel_data : '0;
endmodule

// File: rtl/dcd_sram_ctl.sv
`timescale 1ns/1ps
module dcd_sram_ctl
    import dcd_sram_pkg::*;
#(
    parameter int ADDR_W  = 6,
    parameter int DATA_W  = 16,
    parameter int BURST_W = 2,
    localparam int LANES  = DATA_W / LANE_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              proc_start_n,
    input  logic              ctl_start_n,
    input  logic              burst_adv_n,
    input  logic              wr_all_n,
    input  logic              wr_bytes_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pipe_mode,
    input  logic              out_en_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_drive
);
    sram_op_e          cur_op;
    logic [LANES-1:0]  lane_mask;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] eff_addr;
    logic              burst_live;
    logic [DATA_W-1:0] rd_word;
    logic              rd_fire;
    logic              a_valid, b_valid;

    sram_cmd_decode #(.LANES(LANES)) u_dec (
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .proc_start_n(proc_start_n), .ctl_start_n(ctl_start_n),
        .burst_adv_n(burst_adv_n), .wr_all_n(wr_all_n),
        .wr_bytes_n(wr_bytes_n), .lane_wr_n(lane_wr_n),
        .burst_live(burst_live), .op(cur_op), .lane_mask(lane_mask)
    );

    sram_burst_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_addr (
        .clk(clk), .rst(rst), .op(cur_op), .addr_in(addr),
        .eff_addr(eff_addr), .live(burst_live)
    );

    assign wr_mask = op_is_write(cur_op) ? lane_mask : '0;
    assign rd_fire = op_is_read(cur_op);

    sram_store #(.ADDR_W(ADDR_W), .LANES(LANES)) u_mem (
        .clk(clk), .addr(eff_addr), .wr_mask(wr_mask),
        .wdata(wdata), .rd_word(rd_word)
    );

    sram_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .rd_fire(rd_fire), .rd_word(rd_word),
        .pipe_mode(pipe_mode), .out_en_n(out_en_n),
        .q(rdata), .drive(rdata_drive),
        .a_valid(a_valid), .b_valid(b_valid)
    );
endmodule

// File: rtl/dcd_sram_ctl_chk.sv
`timescale 1ns/1ps
module dcd_sram_ctl_chk
    import dcd_sram_pkg::*;
#(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_a_n,
    input logic             sel_b,
    input logic             sel_c_n,
    input logic             proc_start_n,
    input logic             wr_all_n,
    input logic             out_en_n,
    input logic             rdata_drive,
    input sram_op_e         op,
    input logic [LANES-1:0] lane_mask,
    input logic             a_valid,
    input logic             b_valid
);
    assert_proc_read_R3: assert property (@(posedge clk) disable iff (rst)
        (!sel_a_n && sel_b && !sel_c_n && !proc_start_n) |-> (op == OP_RD_EXT));

    assert_global_mask_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_all_n |-> (lane_mask == {LANES{1'b1}}));

    assert_oe_release_R10: assert property (@(posedge clk) disable iff (rst)
        out_en_n |-> !rdata_drive);

    assert_write_no_valid_R11: assert property (@(posedge clk) disable iff (rst)
        op_is_write(op) |=> !a_valid);

    assert_desel_first_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DESEL) |=> !a_valid);

    assert_desel_second_R9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_DESEL) |=> ##1 !b_valid);
endmodule

bind dcd_sram_ctl dcd_sram_ctl_chk #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .proc_start_n(proc_start_n), .wr_all_n(wr_all_n), .out_en_n(out_en_n),
    .rdata_drive(rdata_drive), .op(cur_op), .lane_mask(lane_mask),
    .a_valid(a_valid), .b_valid(b_valid)
);

// File: tb/tb_dcd_sram_ctl.sv
`timescale 1ns/1ps
module tb_dcd_sram_ctl;
    logic clk = 0;
    logic rst = 1;
    logic sel_a_n = 1, sel_b = 1, sel_c_n = 0;
    logic proc_start_n = 1, ctl_start_n = 0, burst_adv_n = 1;
    logic wr_all_n = 1, wr_bytes_n = 1;
    logic [1:0]  lane_wr_n = 2'b11;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic pipe_mode = 0, out_en_n = 0;
    logic [15:0] rdata;
    logic rdata_drive;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dcd_sram_ctl dut (.*);

    function automatic logic [15:0] val(int a);
        return 16'hA000 + 16'(a);
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(string req, logic drv_e, logic [15:0] d_e);
        total++;
        if (rdata_drive !== drv_e || rdata !== d_e) begin
            bad++;
            $display("FAIL %s: drive=%b data=%h expected drive=%b data=%h",
                     req, rdata_drive, rdata, drv_e, d_e);
        end
    endtask

    task automatic no_write();
        wr_all_n = 1; wr_bytes_n = 1; lane_wr_n = 2'b11;
    endtask

    task automatic desel();
        sel_a_n = 1; sel_b = 1; sel_c_n = 0;
        proc_start_n = 1; ctl_start_n = 0; no_write();
    endtask

    task automatic start_ctl(logic [5:0] a, logic [15:0] d, logic g_n, logic b_n, logic [1:0] l_n);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        proc_start_n = 1; ctl_start_n = 0;
        addr = a; wdata = d; wr_all_n = g_n; wr_bytes_n = b_n; lane_wr_n = l_n;
    endtask

    task automatic start_proc(logic [5:0] a);
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        proc_start_n = 0; ctl_start_n = 1; addr = a; no_write();
    endtask

    task automatic cont(logic adv_n, logic g_n, logic [15:0] d);
        proc_start_n = 1; ctl_start_n = 1; burst_adv_n = adv_n;
        wr_all_n = g_n; wr_bytes_n = 1; lane_wr_n = 2'b11; wdata = d;
    endtask

    task automatic t_reset();
        chk("R1 reset", 1'b0, 16'h0);
    endtask

    task automatic t_global_write();
        start_ctl(6'd8, 16'h1234, 1'b0, 1'b1, 2'b11); tick();
        chk("R11 write drives nothing", 1'b0, 16'h0);
        start_proc(6'd8); tick();
        chk("R5/R8 flow read after global write", 1'b1, 16'h1234);
        desel(); tick();
    endtask

    task automatic t_byte_write();
        start_ctl(6'd8, 16'hFFCD, 1'b1, 1'b0, 2'b10); tick();
        start_ctl(6'd8, 16'hEEFF, 1'b1, 1'b0, 2'b01); tick();
        start_ctl(6'd8, 16'h0000, 1'b1, 1'b1, 2'b00); tick();
        chk("R7 byte lanes, bytes-enable high is read", 1'b1, 16'hEECD);
        start_ctl(6'd8, 16'h0000, 1'b1, 1'b0, 2'b11); tick();
        chk("R7 no lane strobe is read", 1'b1, 16'hEECD);
        desel(); tick();
    endtask

    task automatic t_proc_ignores_write();
        start_proc(6'd8); wr_all_n = 0; wdata = 16'h5555; tick();
        chk("R3 processor strobe reads", 1'b1, 16'hEECD);
        start_proc(6'd8); tick();
        chk("R3 array unchanged", 1'b1, 16'hEECD);
        desel(); tick();
    endtask

    task automatic t_burst();
        start_ctl(6'd13, val(13), 1'b0, 1'b1, 2'b11); tick();
        cont(1'b0, 1'b0, val(14)); tick();
        cont(1'b0, 1'b0, val(15)); tick();
        cont(1'b0, 1'b0, val(12)); tick();
        start_proc(6'd13); tick();
        chk("R6 burst first", 1'b1, val(13));
        cont(1'b0, 1'b1, 16'h0); tick();
        chk("R6 advance", 1'b1, val(14));
        tick(); chk("R6 advance", 1'b1, val(15));
        tick(); chk("R6 wrap", 1'b1, val(12));
        cont(1'b1, 1'b1, 16'h0); tick();
        chk("R6 hold", 1'b1, val(12));
        sel_a_n = 1; proc_start_n = 0; ctl_start_n = 1; burst_adv_n = 1; addr = 6'd3; tick();
        chk("R4 processor strobe ignored", 1'b1, val(12));
    endtask

    task automatic t_deselect_and_idle();
        sel_a_n = 0; sel_b = 0; sel_c_n = 0; proc_start_n = 0; ctl_start_n = 1; addr = 6'd8; tick();
        chk("R2/R9 enable b low deselects, flow release", 1'b0, 16'h0);
        sel_a_n = 0; sel_b = 1; sel_c_n = 1; proc_start_n = 0; tick();
        chk("R2 enable c high deselects", 1'b0, 16'h0);
        sel_a_n = 1; sel_b = 1; sel_c_n = 0; proc_start_n = 1; ctl_start_n = 0; tick();
        chk("R2 enable a high deselects", 1'b0, 16'h0);
        sel_a_n = 0; cont(1'b0, 1'b0, 16'h9999); tick();
        chk("R12 idle drives nothing", 1'b0, 16'h0);
        tick();
        start_proc(6'd12); tick();
        chk("R12 idle wrote nothing", 1'b1, val(12));
        start_proc(6'd13); tick();
        chk("R12 idle wrote nothing", 1'b1, val(13));
        desel(); tick();
    endtask

    task automatic t_pipeline();
        pipe_mode = 1; tick();
        start_proc(6'd8); tick();
        chk("R8 pipeline not yet", 1'b0, 16'h0);
        desel(); tick();
        chk("R8/R9 pipeline data during deselect", 1'b1, 16'hEECD);
        tick();
        chk("R9 pipeline release", 1'b0, 16'h0);
        start_proc(6'd14); tick();
        cont(1'b1, 1'b1, 16'h0); tick();
        chk("R8 pipeline read", 1'b1, val(14));
        out_en_n = 1; #0.5;
        chk("R10 async release", 1'b0, 16'h0);
        out_en_n = 0; #0.5;
        chk("R10 async restore", 1'b1, val(14));
        desel(); tick(); tick(); tick();
        pipe_mode = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_global_write();
        t_byte_write();
        t_proc_ignores_write();
        t_burst();
        t_deselect_and_idle();
        t_pipeline();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule